// File: doc/BRIEF.md
# Connection Request Retry Tracker

This block keeps the two retry fields that a phy places in each outgoing connection-request (OPEN) frame: the count of pathway-blocked rejections and the arbitration wait time. The first attempt of a request always carries zero in both fields. Later attempts of the same request carry the rejection history and the time that has passed since the first attempt.

The link layer pulses `sendOpen` each time it launches an OPEN frame. It reports the outcome of the attempt with `rejBlocked`, `rejArb` or `accepted`. The field values are captured in output registers on each accepted send-open pulse, so they stay constant while the frame is built. A free-running `usTick` pulse measures elapsed time in microseconds. An accepted connection, an explicit `abandon` or a `newReq` pulse ends the current request and clears its history.

Top module: `conn_retry_tracker`

## Requirements
- R1: After reset both output fields are zero, and the next send-open is treated as a first attempt.
- R2: A send-open that is the first attempt of a request sets both output fields to zero.
- R3: On a retry send-open, `outBlockedCnt` equals the number of pathway-blocked rejections received for the current request.
- R4: On a retry send-open that follows an arbitration-lost rejection, `outWaitTime` equals the number of `usTick` cycles strictly after the first attempt's send-open cycle and strictly before the retry's send-open cycle.
- R5: On a retry send-open that follows a pathway-blocked rejection, `outWaitTime` is zero.
- R6: The pathway-blocked count saturates at 255 and does not wrap.
- R7: The wait time saturates at 65535 and does not wrap.
- R8: The outputs change only in the cycle after an accepted send-open, a clear, or reset. Rejections and ticks alone leave them unchanged.
- R9: An `accepted` pulse clears both outputs and the rejection history, so the next send-open is a first attempt.
- R10: An `abandon` or `newReq` pulse has the same clearing effect as `accepted`.
- R11: A rejection arriving while no attempt is outstanding is ignored. A send-open arriving while an attempt is still outstanding is ignored.
- R12: If both rejection inputs pulse in the same cycle, the event counts as a pathway-blocked rejection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newReq | input | 1 | Start of a new request; clears history |
| sendOpen | input | 1 | An OPEN frame is launched now |
| rejBlocked | input | 1 | Outstanding attempt rejected: pathway blocked |
| rejArb | input | 1 | Outstanding attempt lost arbitration |
| accepted | input | 1 | Connection established; clears history |
| abandon | input | 1 | Request given up; clears history |
| usTick | input | 1 | One-cycle pulse per microsecond |
| outBlockedCnt | output | 8 | Pathway-blocked count field for the current frame |
| outWaitTime | output | 16 | Arbitration wait time field for the current frame |

## Verification
Some properties are checked on every cycle by assertions:
- the output registers hold still unless a latch or a clear strobe fires (R8);
- a first-attempt latch yields zeros (R2);
- neither counter ever wraps or moves backwards between clears (R6, R7);
- two latches never occur in consecutive cycles (R11).

Other behaviour only the bench scenarios can show. These are the exact field values after mixed sequences of rejections and ticks (R3, R4, R5), and the effect of clears on the next attempt (R9, R10). They also cover the tie-breaking of simultaneous rejections (R12) and the reaching of both saturation limits through long runs.

// File: rtl/conn_retry_pkg.sv
package conn_retry_pkg;
  typedef struct packed {
    logic clrAll;
    logic latchFirst;
    logic latchRetry;
    logic startTimer;
    logic incBlocked;
    logic setArb;
  } retryStrobes_t;

  typedef enum logic [1:0] {
    ST_FRESH = 2'd0,
    ST_OUT   = 2'd1,
    ST_RETRY = 2'd2
  } retryState_t;
endpackage

// File: rtl/retry_sat_counter.sv
module retry_sat_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (inc && value != MAXV) begin
      value <= value + 1'b1;
    end
  end

  // R6 / R7: no wrap, monotonic between clears
  a_r6_r7_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!clr) |=> (value >= $past(value)));
  a_r6_r7_hold_max: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && value == MAXV) |=> (value == MAXV));
endmodule

// File: rtl/conn_retry_ctrl.sv
module conn_retry_ctrl
  import conn_retry_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          newReq,
  input  logic          sendOpen,
  input  logic          rejBlocked,
  input  logic          rejArb,
  input  logic          accepted,
  input  logic          abandon,
  output retryStrobes_t strobes
);
  retryState_t state, nextState;
  logic clearReq;

  assign clearReq = newReq | accepted | abandon;

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (clearReq) begin
      strobes.clrAll = 1'b1;
      nextState      = ST_FRESH;
    end else begin
      unique case (state)
        ST_FRESH: if (sendOpen) begin
          strobes.latchFirst = 1'b1;
          strobes.startTimer = 1'b1;
          nextState          = ST_OUT;
        end
        ST_OUT: begin
          if (rejBlocked) begin
            strobes.incBlocked = 1'b1;
            nextState          = ST_RETRY;
          end else if (rejArb) begin
            strobes.setArb = 1'b1;
            nextState      = ST_RETRY;
          end
        end
        ST_RETRY: if (sendOpen) begin
          strobes.latchRetry = 1'b1;
          nextState          = ST_OUT;
        end
        default: nextState = ST_FRESH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FRESH;
    else       state <= nextState;
  end

  // R11: at most one latch-or-clear action per cycle, and never two latches back to back
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clrAll, strobes.latchFirst, strobes.latchRetry}));
  a_r11_no_double_latch: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchFirst || strobes.latchRetry) |=> !(strobes.latchFirst || strobes.latchRetry));
endmodule

// File: rtl/conn_retry_datapath.sv
module conn_retry_datapath
  import conn_retry_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  retryStrobes_t     strobes,
  input  logic              usTick,
  output logic [BLK_W-1:0]  outBlockedCnt,
  output logic [WAIT_W-1:0] outWaitTime
);
  logic [BLK_W-1:0]  blockedCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              timerOn;
  logic              lastArb;

  retry_sat_counter #(.WIDTH(BLK_W)) uBlocked (
    .clk(clk), .rstN(rstN), .clr(strobes.clrAll),
    .inc(strobes.incBlocked), .value(blockedCnt));

  retry_sat_counter #(.WIDTH(WAIT_W)) uWait (
    .clk(clk), .rstN(rstN), .clr(strobes.clrAll),
    .inc(timerOn & usTick), .value(waitCnt));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerOn       <= 1'b0;
      lastArb       <= 1'b0;
      outBlockedCnt <= '0;
      outWaitTime   <= '0;
    end else if (strobes.clrAll) begin
      timerOn       <= 1'b0;
      lastArb       <= 1'b0;
      outBlockedCnt <= '0;
      outWaitTime   <= '0;
    end else begin
      if (strobes.startTimer) timerOn <= 1'b1;
      if (strobes.incBlocked) lastArb <= 1'b0;
      else if (strobes.setArb) lastArb <= 1'b1;
      if (strobes.latchFirst) begin
        outBlockedCnt <= '0;
        outWaitTime   <= '0;
      end else if (strobes.latchRetry) begin
        outBlockedCnt <= blockedCnt;
        outWaitTime   <= lastArb ? waitCnt : '0;
      end
    end
  end

  // R8: fields move only on a latch or clear
  a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clrAll && !strobes.latchFirst && !strobes.latchRetry)
      |=> ($stable(outBlockedCnt) && $stable(outWaitTime)));
  // R2: first attempt carries zero fields
  a_r2_first_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchFirst |=> (outBlockedCnt == '0 && outWaitTime == '0));
endmodule

// File: rtl/conn_retry_tracker.sv
module conn_retry_tracker
  import conn_retry_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newReq,
  input  logic              sendOpen,
  input  logic              rejBlocked,
  input  logic              rejArb,
  input  logic              accepted,
  input  logic              abandon,
  input  logic              usTick,
  output logic [BLK_W-1:0]  outBlockedCnt,
  output logic [WAIT_W-1:0] outWaitTime
);
  retryStrobes_t strobes;

  conn_retry_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .newReq(newReq), .sendOpen(sendOpen),
    .rejBlocked(rejBlocked), .rejArb(rejArb), .accepted(accepted),
    .abandon(abandon), .strobes(strobes));

  conn_retry_datapath #(.BLK_W(BLK_W), .WAIT_W(WAIT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .usTick(usTick),
    .outBlockedCnt(outBlockedCnt), .outWaitTime(outWaitTime));
endmodule

// File: tb/tb_conn_retry_tracker.sv
module tb_conn_retry_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic newReq = 0, sendOpen = 0, rejBlocked = 0, rejArb = 0;
  logic accepted = 0, abandon = 0, usTick = 0;
  logic [7:0]  outBlockedCnt;
  logic [15:0] outWaitTime;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  conn_retry_tracker dut (
    .clk(clk), .rstN(rstN), .newReq(newReq), .sendOpen(sendOpen),
    .rejBlocked(rejBlocked), .rejArb(rejArb), .accepted(accepted),
    .abandon(abandon), .usTick(usTick),
    .outBlockedCnt(outBlockedCnt), .outWaitTime(outWaitTime));

  task automatic chk(input string req, input int expB, input int expW);
    checks++;
    if (outBlockedCnt != expB[7:0] || outWaitTime != expW[15:0]) begin
      errors++;
      $display("FAIL %s: blocked=%0d wait=%0d expected blocked=%0d wait=%0d",
               req, outBlockedCnt, outWaitTime, expB, expW);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      usTick = 1; @(negedge clk); usTick = 0;
    end
  endtask
  task automatic send();     sendOpen = 1;   @(negedge clk); sendOpen = 0;   endtask
  task automatic rejB();     rejBlocked = 1; @(negedge clk); rejBlocked = 0; endtask
  task automatic rejA();     rejArb = 1;     @(negedge clk); rejArb = 0;     endtask
  task automatic doAccept(); accepted = 1;   @(negedge clk); accepted = 0;   endtask
  task automatic doAbandon(); abandon = 1;   @(negedge clk); abandon = 0;    endtask
  task automatic doNew();    newReq = 1;     @(negedge clk); newReq = 0;     endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    chk("R1 reset", 0, 0);

    // R3 R4 R5 sweep over reject counts, tick gaps and last reject kind
    for (int nb = 0; nb < 4; nb++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int gap = 0; gap < 3; gap++) begin
          int tot;
          doNew();
          ticks(2);
          send();
          chk("R2 first attempt", 0, 0);
          tot = 0;
          for (int i = 0; i < nb; i++) begin
            ticks(gap); tot += gap;
            rejB();
            send();
          end
          ticks(gap + 1); tot += gap + 1;
          if (kind == 1) begin
            rejA();
            chk("R8 held after reject", nb, 0);
            send();
            chk("R3 R4 arb retry", nb, tot);
          end else begin
            rejB();
            send();
            chk("R3 R5 blocked retry", nb + 1, 0);
          end
        end
      end
    end

    // R4: ticks during rejected gap and tick in same cycle as first send
    doNew();
    usTick = 1; send(); usTick = 0;
    ticks(3); rejA(); ticks(4);
    send();
    chk("R4 elapsed incl. post-reject ticks", 0, 7);

    // R8: ticks and rejects after a send leave fields alone
    ticks(5);
    chk("R8 stable under ticks", 0, 7);

    // R11: reject while no attempt outstanding; send while outstanding
    rejB();
    rejB();
    send();
    chk("R11 extra reject ignored", 1, 0);
    ticks(2);
    send();
    chk("R11 send while outstanding ignored", 1, 0);

    // R12: simultaneous rejects count as pathway blocked
    rejBlocked = 1; rejArb = 1; @(negedge clk); rejBlocked = 0; rejArb = 0;
    send();
    chk("R12 both rejects", 2, 0);

    // R9: accepted clears
    doAccept();
    chk("R9 cleared by accept", 0, 0);
    ticks(3);
    send();
    chk("R9 next is first attempt", 0, 0);
    rejA(); send();
    chk("R9 history restarted", 0, 0);

    // R10: abandon clears
    rejB(); send();
    chk("R10 pre-abandon", 1, 0);
    doAbandon();
    chk("R10 cleared by abandon", 0, 0);
    send(); rejB(); send();
    chk("R10 history restarted", 1, 0);

    // R6: saturation of blocked count
    doNew(); send();
    for (int i = 0; i < 300; i++) begin rejB(); send(); end
    chk("R6 blocked saturates", 255, 0);

    // R7: saturation of wait time
    doNew(); send();
    ticks(70000);
    rejA(); send();
    chk("R7 wait saturates", 0, 65535);

    // R1: reset mid-request clears and rearms
    rstN = 0; idle(2); rstN = 1; idle(1);
    chk("R1 reset clears", 0, 0);
    send();
    chk("R1 first after reset", 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule